// File: doc/BRIEF.md
# SPI Target Receive Path with Length-Aware Interrupt

This block is the receive side of an SPI target. Bytes shifted in on MOSI while chip select is low are assembled MSB first and written into a byte-wide receive FIFO. The processor drains the FIFO one 32-bit word at a time. A small 8-bit register port holds the trigger settings, the interrupt enables and the interrupt status.

In length mode the interrupt threshold is not fixed. Software programs a header byte count and the byte position of a two-byte length field. While the frame arrives, the block captures that field from the stream and raises the valid-length status once the byte count reaches header count plus captured length. The processor can then parse the whole request as soon as it is complete, without waiting for a large fixed fill level.

In fallback mode the block raises a separate fill-level status when the FIFO holds a fixed number of bytes. Raising chip select empties the FIFO and restarts all per-transaction counting.

Top module: `spi_rxlen_target`

## Requirements
- R1: The 16-bit header count is held in register 0 (bits 7:0) and register 1 (bits 15:8). Both registers read back what was written.
- R2: The 16-bit length offset is held in register 2 (low byte) and register 3 (high byte). The length field is little-endian: the frame byte at index offset is bits 7:0 and the byte at index offset+1 is bits 15:8, where index 0 is the first byte after chip select falls.
- R3: In length mode (register 6 bit 0 = 1), status bit 0 (register 5) sets once both length bytes are captured and the received byte count is at least header count plus length. It never sets earlier.
- R4: Writing register 5 clears each status bit written as 1 and leaves the bits written as 0 unchanged. When a set and a clear meet in the same cycle, the set wins.
- R5: The irq output is high exactly when some status bit is set and its bit in the mask register (register 4, bits 2:0) is 0. A mask bit of 1 disables that source.
- R6: Each trigger status sets at most once per chip-select-framed transaction. It does not set if chip select rises before the threshold is reached.
- R7: A rising chip select empties the FIFO and clears the byte count, the captured length and the once-per-transaction flags.
- R8: fifo_rdata shows the oldest four FIFO bytes, with the oldest in bits 7:0 and missing bytes as zero. A one-cycle fifo_rd pulse removes min(4, fifo_level) bytes. fifo_level gives the byte count.
- R9: In fallback mode (register 6 bit 0 = 0), status bit 1 sets when the FIFO holds REACH_LEVEL (default 256) bytes. Status bit 0 never sets in this mode.
- R10: A byte that arrives while the FIFO holds FIFO_DEPTH bytes is dropped and sets status bit 2. That bit stays set across transactions until it is cleared by a write of 1.
- R11: SPI is mode 0 and MSB first. Data is sampled on the SCK rising edge while chip select is low, and all pins are synchronised to clk.
- R12: After reset, registers 0 to 3 read 0, the mask reads 0x07, the status reads 0, the mode reads 0, the FIFO is empty and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, at most clk/4 |
| spi_mosi | input | 1 | SPI data from the controller |
| spi_csn | input | 1 | SPI chip select, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| fifo_rd | input | 1 | Pop one word from the FIFO |
| fifo_rdata | output | 32 | Oldest FIFO bytes, little-endian |
| fifo_level | output | 9 | Bytes held in the FIFO |
| irq | output | 1 | Interrupt, high while an unmasked status is set |

## Verification
The first frame places its length field inside a short header. The bench checks that the status stays clear one byte before header plus length and sets on the byte that completes it. A second frame puts a nonzero high byte in the length field, so that little-endian and big-endian capture would fire 255 bytes apart. The same frame overruns the FIFO, so it also shows the sticky overflow flag surviving a chip-select rise. An aborted frame followed by a fresh one separates correct per-transaction reset from carried-over counts. A long frame in fallback mode checks the fixed fill-level trigger and shows that the length trigger stays quiet in that mode.

// File: rtl/spi_rxlen_pkg.sv
// Shared constants for the SPI target receive path: register map,
// status bit positions and fixed field widths.
package spi_rxlen_pkg;
    localparam int REG_AW = 3;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ST_W   = 3;

    localparam logic [REG_AW-1:0] RA_TGT_LO = 3'd0;
    localparam logic [REG_AW-1:0] RA_TGT_HI = 3'd1;
    localparam logic [REG_AW-1:0] RA_OFS_LO = 3'd2;
    localparam logic [REG_AW-1:0] RA_OFS_HI = 3'd3;
    localparam logic [REG_AW-1:0] RA_MASK   = 3'd4;
    localparam logic [REG_AW-1:0] RA_STAT   = 3'd5;
    localparam logic [REG_AW-1:0] RA_MODE   = 3'd6;

    localparam int ST_VLEN  = 0;
    localparam int ST_REACH = 1;
    localparam int ST_OVF   = 2;

    typedef logic [ST_W-1:0] stat_t;
endpackage

// File: rtl/spi_rxlen_sync.sv
// Synchronises SCK, MOSI and CS# into clk and assembles bytes MSB first.
// Assumes SPI mode 0 and SCK no faster than clk/4. byte_valid_o pulses for
// one cycle, STAGES+1 cycles after the eighth sampled SCK rising edge.
module spi_rxlen_sync
    import spi_rxlen_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              csn_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              cs_end_o
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [STAGES:0]   sck_q, mosi_q, csn_q;
    logic [BC_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              sck_rise, cs_idle, mosi_s;

    // Synchroniser chains with one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            mosi_q <= '0;
            csn_q  <= '1;
        end else begin
            sck_q  <= {sck_q[STAGES-1:0], sck_i};
            mosi_q <= {mosi_q[STAGES-1:0], mosi_i};
            csn_q  <= {csn_q[STAGES-1:0], csn_i};
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign cs_idle  = csn_q[STAGES-1];
    assign mosi_s   = mosi_q[STAGES-1];
    assign cs_end_o = csn_q[STAGES-1] & ~csn_q[STAGES];

    // Shift in bits on SCK rising edges and emit a byte after every eighth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
        end else begin
            byte_valid_o <= 1'b0;
            if (cs_idle) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BC_W'(BYTE_W - 1)) begin
                    byte_o       <= {shreg, mosi_s};
                    byte_valid_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_rxlen_fifo.sv
// Byte-in, word-out receive FIFO. A write while full is dropped and flagged.
// A read pops up to four bytes. The head word is shown little-endian with
// missing bytes as zero. flush empties it at once. DEPTH must be a power of two.
module spi_rxlen_fifo
    import spi_rxlen_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [4*BYTE_W-1:0] rd_word,
    output logic [LVL_W-1:0]    level,
    output logic                drop_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, do_wr;
    logic [LVL_W-1:0]  pop_n, rd_n;

    assign full   = (level == LVL_W'(DEPTH));
    assign do_wr  = wr_en & ~full & ~flush;
    assign drop_o = wr_en & full;
    assign pop_n  = (level >= LVL_W'(4)) ? LVL_W'(4) : level;
    assign rd_n   = rd_en ? pop_n : '0;

    // Storage array, written only on an accepted byte.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointers and fill level, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            rd_ptr <= rd_ptr + PTR_W'(rd_n);
            level  <= level + LVL_W'(do_wr) - rd_n;
        end
    end

    // Head word assembly, one byte lane per generate step.
    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign rd_word[i*BYTE_W +: BYTE_W] =
            (level > LVL_W'(i)) ? mem[rd_ptr + PTR_W'(i)] : '0;
    end
endmodule

// File: rtl/spi_rxlen_trig.sv
// Per-transaction byte counter and length capture. It collects the
// little-endian length field at offset and offset+1, then asserts fire_o
// once the count reaches target + length. Fires at most once per transaction.
module spi_rxlen_trig
    import spi_rxlen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_end,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              len_mode,
    input  logic [CNT_W-1:0]  target,
    input  logic [CNT_W-1:0]  offset,
    output logic              fire_o,
    output logic              len_full_o
);
    logic [CNT_W-1:0] cnt, len_val;
    logic             have_lo, have_hi, fired;
    logic [CNT_W:0]   thr, ofs_nx;

    assign thr        = {1'b0, target} + {1'b0, len_val};
    assign ofs_nx     = {1'b0, offset} + 1'b1;
    assign len_full_o = have_lo & have_hi;
    assign fire_o     = len_mode & len_full_o & ~fired & ({1'b0, cnt} >= thr);

    // Count bytes, capture the length field and remember the firing.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_end) begin
            cnt     <= '0;
            len_val <= '0;
            have_lo <= 1'b0;
            have_hi <= 1'b0;
            fired   <= 1'b0;
        end else begin
            if (fire_o) fired <= 1'b1;
            if (byte_valid) begin
                if (cnt == offset) begin
                    len_val[BYTE_W-1:0] <= byte_data;
                    have_lo             <= 1'b1;
                end
                if ({1'b0, cnt} == ofs_nx) begin
                    len_val[CNT_W-1:BYTE_W] <= byte_data;
                    have_hi                 <= 1'b1;
                end
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rxlen_target.sv
// Top of the SPI target receive path: synchroniser, FIFO, length trigger,
// fill-level trigger, register file and interrupt. Assumes one register
// access per cycle and that FIFO reads are issued only while CS# is low.
module spi_rxlen_target
    import spi_rxlen_pkg::*;
#(
    parameter int FIFO_DEPTH  = 256,
    parameter int REACH_LEVEL = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              spi_sck,
    input  logic                              spi_mosi,
    input  logic                              spi_csn,
    input  logic                              reg_we,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [BYTE_W-1:0]                 reg_wdata,
    output logic [BYTE_W-1:0]                 reg_rdata,
    input  logic                              fifo_rd,
    output logic [4*BYTE_W-1:0]               fifo_rdata,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
    output logic                              irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              byte_valid, cs_end, drop, len_fire, len_full;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  tgt_q, ofs_q;
    stat_t             mask_q, status_q, st_set, st_clr;
    logic              mode_q, reach_fired, reach_fire;

    spi_rxlen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck), .mosi_i(spi_mosi), .csn_i(spi_csn),
        .byte_valid_o(byte_valid), .byte_o(rx_byte), .cs_end_o(cs_end)
    );

    spi_rxlen_fifo #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(cs_end),
        .wr_en(byte_valid), .wr_data(rx_byte),
        .rd_en(fifo_rd), .rd_word(fifo_rdata),
        .level(fifo_level), .drop_o(drop)
    );

    spi_rxlen_trig u_trig (
        .clk(clk), .rst_n(rst_n), .cs_end(cs_end),
        .byte_valid(byte_valid), .byte_data(rx_byte),
        .len_mode(mode_q), .target(tgt_q), .offset(ofs_q),
        .fire_o(len_fire), .len_full_o(len_full)
    );

    // Fixed fill-level trigger, used only in fallback mode.
    assign reach_fire = ~mode_q & ~reach_fired & (fifo_level >= LVL_W'(REACH_LEVEL));

    // Once-per-transaction flag for the fill-level trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_end) reach_fired <= 1'b0;
        else if (reach_fire)  reach_fired <= 1'b1;
    end

    // Configuration registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            ofs_q  <= '0;
            mask_q <= '1;
            mode_q <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_TGT_LO: tgt_q[BYTE_W-1:0]     <= reg_wdata;
                RA_TGT_HI: tgt_q[CNT_W-1:BYTE_W] <= reg_wdata;
                RA_OFS_LO: ofs_q[BYTE_W-1:0]     <= reg_wdata;
                RA_OFS_HI: ofs_q[CNT_W-1:BYTE_W] <= reg_wdata;
                RA_MASK:   mask_q                <= reg_wdata[ST_W-1:0];
                RA_MODE:   mode_q                <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        st_set           = '0;
        st_set[ST_VLEN]  = len_fire;
        st_set[ST_REACH] = reach_fire;
        st_set[ST_OVF]   = drop;
    end
    assign st_clr = (reg_we && reg_addr == RA_STAT) ? reg_wdata[ST_W-1:0] : '0;

    // Status bits: write-one-to-clear, with a new event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~st_clr) | st_set;
    end

    assign irq = |(status_q & ~mask_q);

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_TGT_LO: reg_rdata = tgt_q[BYTE_W-1:0];
            RA_TGT_HI: reg_rdata = tgt_q[CNT_W-1:BYTE_W];
            RA_OFS_LO: reg_rdata = ofs_q[BYTE_W-1:0];
            RA_OFS_HI: reg_rdata = ofs_q[CNT_W-1:BYTE_W];
            RA_MASK:   reg_rdata = BYTE_W'(mask_q);
            RA_STAT:   reg_rdata = BYTE_W'(status_q);
            RA_MODE:   reg_rdata = BYTE_W'(mode_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_rxlen_chk.sv
// Assertion checker for spi_rxlen_target, attached by bind below.
module spi_rxlen_chk
    import spi_rxlen_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ST_W-1:0]             status,
    input logic [ST_W-1:0]             mask,
    input logic                        irq,
    input logic                        cs_end,
    input logic                        len_full,
    input logic                        len_mode,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_level,
    input logic                        reg_we,
    input logic [REG_AW-1:0]           reg_addr,
    input logic [BYTE_W-1:0]           reg_wdata
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [1:0] len_sets;
    logic       vlen_q;

    // Counts valid-length status rises inside one transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_sets <= '0;
            vlen_q   <= 1'b0;
        end else begin
            vlen_q <= status[ST_VLEN];
            if (cs_end) len_sets <= '0;
            else if (status[ST_VLEN] && !vlen_q && len_sets != 2'd3) len_sets <= len_sets + 1'b1;
        end
    end

    assert_irq_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_VLEN] && !mask[ST_VLEN]) |-> irq);
    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    assert_len_captured_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_VLEN]) |-> $past(len_full && len_mode));
    assert_len_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        len_sets <= 2'd1);
    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> (fifo_level == '0));
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_OVF] && !(reg_we && reg_addr == RA_STAT && reg_wdata[ST_OVF])) |=> status[ST_OVF]);
    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));
endmodule

bind spi_rxlen_target spi_rxlen_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q), .irq(irq),
    .cs_end(cs_end), .len_full(len_full), .len_mode(mode_q),
    .fifo_level(fifo_level), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/spi_rxlen_target_tb.sv
// Bench for spi_rxlen_target: a behavioural reference model advanced on
// every clock and compared before each rising edge, plus directed checks.
module spi_rxlen_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int REACH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        fifo_rd = 1'b0;
    logic [31:0] fifo_rdata;
    logic [8:0]  fifo_level;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    spi_rxlen_target u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_csn(spi_csn), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_level(fifo_level), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0] mq[$];
    int   m_tgt, m_ofs, m_cnt, m_len, m_edge;
    logic [2:0] m_mask, m_stat;
    logic m_mode, m_lo, m_hi, m_len_fired, m_reach_fired, f_len, f_reach;
    logic prev_sck, prev_csn;
    logic [7:0] shv;
    int   nbits;
    logic       p_byte [8];
    logic [7:0] p_dat  [8];
    logic       p_cse  [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_tgt = 0; m_ofs = 0; m_cnt = 0; m_len = 0; m_edge = 0;
            m_mask = 3'b111; m_stat = 3'b000; m_mode = 1'b0;
            m_lo = 0; m_hi = 0; m_len_fired = 0; m_reach_fired = 0;
            f_len = 0; f_reach = 0; prev_sck = 0; prev_csn = 1; shv = 0; nbits = 0;
            for (int i = 0; i < 8; i++) begin p_byte[i] = 0; p_dat[i] = 0; p_cse[i] = 0; end
        end else begin
            int s, old;
            logic [2:0] st;
            s = m_edge % 8;
            st = m_stat;
            if (reg_we && reg_addr == 3'd5) st = st & ~reg_wdata[2:0];
            if (f_len)   begin st[0] = 1'b1; m_len_fired = 1'b1; end
            if (f_reach) begin st[1] = 1'b1; m_reach_fired = 1'b1; end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_tgt = (m_tgt & 32'hFF00) | int'(reg_wdata);
                    3'd1: m_tgt = (m_tgt & 32'h00FF) | (int'(reg_wdata) << 8);
                    3'd2: m_ofs = (m_ofs & 32'hFF00) | int'(reg_wdata);
                    3'd3: m_ofs = (m_ofs & 32'h00FF) | (int'(reg_wdata) << 8);
                    3'd4: m_mask = reg_wdata[2:0];
                    3'd6: m_mode = reg_wdata[0];
                    default: ;
                endcase
            end
            old = mq.size();
            if (p_byte[s] && old == DEPTH) st[2] = 1'b1;
            if (p_cse[s]) begin
                mq.delete();
                m_cnt = 0; m_len = 0; m_lo = 0; m_hi = 0;
                m_len_fired = 0; m_reach_fired = 0;
            end else begin
                if (fifo_rd) begin
                    for (int k = 0; k < 4 && k < old; k++) void'(mq.pop_front());
                end
                if (p_byte[s]) begin
                    if (old != DEPTH) mq.push_back(p_dat[s]);
                    if (m_cnt == m_ofs)     begin m_len = (m_len & 32'hFF00) | int'(p_dat[s]); m_lo = 1; end
                    if (m_cnt == m_ofs + 1) begin m_len = (m_len & 32'h00FF) | (int'(p_dat[s]) << 8); m_hi = 1; end
                    if (m_cnt < 65535) m_cnt++;
                end
            end
            m_stat = st;
            p_byte[s] = 0; p_cse[s] = 0;
            if (spi_csn) nbits = 0;
            else if (spi_sck && !prev_sck) begin
                shv = {shv[6:0], spi_mosi};
                nbits++;
                if (nbits == 8) begin
                    p_byte[(m_edge + 3) % 8] = 1'b1;
                    p_dat[(m_edge + 3) % 8]  = shv;
                    nbits = 0;
                end
            end
            if (spi_csn && !prev_csn) p_cse[(m_edge + 2) % 8] = 1'b1;
            prev_sck = spi_sck; prev_csn = spi_csn;
            f_len   = m_mode && m_lo && m_hi && !m_len_fired && (m_cnt >= m_tgt + m_len);
            f_reach = !m_mode && !m_reach_fired && (mq.size() >= REACH);
            m_edge++;
        end
    end

    // Compare against the model once per cycle, away from both edges.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            logic [31:0] w;
            w = 32'd0;
            for (int i = 0; i < 4; i++) if (i < mq.size()) w[8*i +: 8] = mq[i];
            chk("R5 irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
            chk("R8 level", {23'd0, fifo_level}, mq.size());
            chk("R8 word", fifo_rdata, w);
            if (reg_addr == 3'd5 && !reg_we) chk("R3 status", {24'd0, reg_rdata}, {29'd0, m_stat});
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic reg_read_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, {24'd0, reg_rdata}, {24'd0, e});
        @(negedge clk);
        reg_addr = 3'd5;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int j = 7; j >= 0; j--) begin
            @(negedge clk); spi_mosi = b[j];
            repeat (3) @(negedge clk); spi_sck = 1'b1;
            repeat (4) @(negedge clk); spi_sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk); spi_csn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_finish();
        repeat (4) @(negedge clk); spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pop_word();
        @(negedge clk); fifo_rd = 1'b1;
        @(negedge clk); fifo_rd = 1'b0;
    endtask

    function automatic logic [7:0] frame_a(input int i);
        if (i == 6) return 8'h03;
        if (i == 7) return 8'h00;
        return 8'(8'h30 + i);
    endfunction

    function automatic logic [7:0] frame_b(input int i);
        if (i == 2) return 8'h00;
        if (i == 3) return 8'h01;
        return 8'(i);
    endfunction

    // ---------------- directed sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        // R12: reset values
        chk("R12 irq", {31'd0, irq}, 32'd0);
        chk("R12 level", {23'd0, fifo_level}, 32'd0);
        reg_read_chk(3'd0, 8'h00, "R12 tgt lo");
        reg_read_chk(3'd1, 8'h00, "R12 tgt hi");
        reg_read_chk(3'd2, 8'h00, "R12 ofs lo");
        reg_read_chk(3'd3, 8'h00, "R12 ofs hi");
        reg_read_chk(3'd4, 8'h07, "R12 mask");
        reg_read_chk(3'd5, 8'h00, "R12 status");
        reg_read_chk(3'd6, 8'h00, "R12 mode");

        // R1 / R2: programming and readback
        reg_write(3'd1, 8'hA5);
        reg_read_chk(3'd1, 8'hA5, "R1 tgt hi");
        reg_write(3'd1, 8'h00);
        reg_write(3'd0, 8'h10);
        reg_read_chk(3'd0, 8'h10, "R1 tgt lo");
        reg_write(3'd2, 8'h06);
        reg_write(3'd3, 8'h00);
        reg_read_chk(3'd2, 8'h06, "R2 ofs lo");
        reg_write(3'd6, 8'h01);
        reg_write(3'd4, 8'h06);

        // Frame A: header 16, length 3 at offset 6 -> fires on byte 19
        cs_begin();
        for (int i = 0; i < 18; i++) spi_byte(frame_a(i));
        settle(6);
        chk("R3 not before threshold", {24'd0, reg_rdata}, 32'h0);
        spi_byte(frame_a(18));
        settle(6);
        chk("R3 fires at threshold", {24'd0, reg_rdata}, 32'h1);
        chk("R5 irq unmasked", {31'd0, irq}, 32'd1);
        chk("R11 R8 head word", fifo_rdata, 32'h33323130);
        pop_word();
        settle(1);
        chk("R8 next word", fifo_rdata, 32'h00033534);
        chk("R8 level after pop", {23'd0, fifo_level}, 32'd15);
        reg_write(3'd5, 8'h00);
        settle(1);
        chk("R4 zero write keeps bit", {24'd0, reg_rdata}, 32'h1);
        reg_write(3'd5, 8'h01);
        settle(1);
        chk("R4 one write clears", {24'd0, reg_rdata}, 32'h0);
        chk("R5 irq low", {31'd0, irq}, 32'd0);
        for (int i = 19; i < 24; i++) spi_byte(8'(i));
        settle(6);
        chk("R6 no second set", {24'd0, reg_rdata}, 32'h0);
        cs_finish();
        settle(1);
        chk("R7 flush on cs", {23'd0, fifo_level}, 32'd0);

        // Frame B: offset 2, header 4, length 0x0100 -> fires on byte 260
        reg_write(3'd2, 8'h02);
        reg_write(3'd0, 8'h04);
        cs_begin();
        for (int i = 0; i < 259; i++) spi_byte(frame_b(i));
        settle(6);
        chk("R2 little-endian no early fire", {24'd0, reg_rdata}, 32'h4);
        chk("R10 level full", {23'd0, fifo_level}, 32'd256);
        chk("R5 ovf masked", {31'd0, irq}, 32'd0);
        spi_byte(frame_b(259));
        settle(6);
        chk("R2 R3 fires at 260", {24'd0, reg_rdata}, 32'h5);
        reg_write(3'd5, 8'h01);
        settle(1);
        chk("R4 per-bit clear", {24'd0, reg_rdata}, 32'h4);
        cs_finish();
        settle(1);
        chk("R10 sticky across cs", {24'd0, reg_rdata}, 32'h4);
        reg_write(3'd5, 8'h04);
        settle(1);
        chk("R10 cleared by write", {24'd0, reg_rdata}, 32'h0);

        // Frame C: aborted, then a fresh frame; header 8, length 4 at offset 0
        reg_write(3'd2, 8'h00);
        reg_write(3'd0, 8'h08);
        cs_begin();
        spi_byte(8'h04); spi_byte(8'h00);
        for (int i = 2; i < 11; i++) spi_byte(8'hC0);
        cs_finish();
        settle(1);
        chk("R6 abort no set", {24'd0, reg_rdata}, 32'h0);
        cs_begin();
        spi_byte(8'h04); spi_byte(8'h00);
        for (int i = 2; i < 11; i++) spi_byte(8'h81);
        settle(6);
        chk("R7 count restarted", {24'd0, reg_rdata}, 32'h0);
        spi_byte(8'h7E);
        settle(6);
        chk("R7 fresh frame fires", {24'd0, reg_rdata}, 32'h1);
        cs_finish();
        reg_write(3'd5, 8'h07);

        // Frame D: fallback mode, fill-level trigger
        reg_write(3'd6, 8'h00);
        reg_write(3'd4, 8'h05);
        cs_begin();
        for (int i = 0; i < 255; i++) spi_byte(8'(255 - i));
        settle(6);
        chk("R9 not before fill", {24'd0, reg_rdata}, 32'h0);
        spi_byte(8'h00);
        settle(6);
        chk("R9 fill reached", {24'd0, reg_rdata}, 32'h2);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        cs_finish();
        reg_write(3'd5, 8'h02);
        settle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule